// File: doc/BRIEF.md
# Single-Port RAM Queue Controller

This block is the control logic that turns a single-port synchronous RAM into a first-in first-out queue. It owns a read pointer, a write pointer and an occupancy count. Each cycle it picks which pointer drives the RAM's one shared address bus and whether the write enable is raised. The RAM, its data buses and any data staging sit outside the block. Because the RAM has only one address port, at most one queue operation is accepted per clock. When push and pop arrive together, the pop wins.

Requests `push_req`, `pop_req` and `init_req` are active high and are sampled on the rising edge of `clk`. The address and write enable are combinational from the current requests and state, so the RAM acts on them at the same edge. The occupancy is tracked by a three-state machine. ST_EMPTY moves to ST_PARTIAL on an accepted push. ST_PARTIAL moves to ST_FULL on a push that fills the last slot, and to ST_EMPTY on a pop that takes the last word. ST_FULL moves to ST_PARTIAL on an accepted pop. Every state returns to ST_EMPTY on `init_req` or on reset. `full` and `empty` decode the state. The two refusal flags are registered and report a request that was turned down in the previous cycle.

Top module: `ramq_ctrl`

## Requirements
- R1: After reset or after a cycle with `init_req` high, `empty`=1, `full`=0, `push_refused`=0 and `pop_refused`=0, and the next accepted push addresses word 0.
- R2: An accepted push (`push_req`=1, `pop_req`=0, `init_req`=0, not full) drives the write pointer on `ram_addr` with `ram_we`=1 in that cycle. The write pointer then advances by one, modulo 2^ADDR_W.
- R3: An accepted pop (`pop_req`=1, `init_req`=0, not empty) drives the read pointer on `ram_addr` with `ram_we`=0. The read pointer then advances by one, modulo 2^ADDR_W.
- R4: In a cycle with no accepted operation, `ram_addr` shows the read pointer and `ram_we` is 0.
- R5: With `push_req` and `pop_req` both high, the pop is performed when the queue is not empty, no write occurs, and `push_refused` is 1 in the following cycle.
- R6: `push_req` while `full` is refused: `ram_we` stays 0, the occupancy is unchanged, and `push_refused` is 1 in the following cycle.
- R7: `pop_req` while `empty` is refused: the read pointer is unchanged, and `pop_refused` is 1 in the following cycle. If `push_req` is high in the same cycle, it is refused too.
- R8: `full` is 1 exactly when 2^ADDR_W words are held, and `empty` is 1 exactly when none are held. Both reflect the operations accepted up to the previous edge.
- R9: Words come back in the order they were written, including across pointer wrap-around.
- R10: `init_req` takes precedence over `push_req` and `pop_req`: no write occurs, no pointer moves other than the clear, and no refusal flag is raised.
- R11: Each refusal flag is 1 for exactly the cycle after a refused request and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to enqueue one word |
| pop_req | input | 1 | Request to dequeue one word |
| init_req | input | 1 | Synchronous clear of the queue |
| ram_addr | output | ADDR_W | Shared RAM address |
| ram_we | output | 1 | RAM write enable, active high |
| full | output | 1 | Queue holds 2^ADDR_W words |
| empty | output | 1 | Queue holds no words |
| push_refused | output | 1 | Previous cycle's push was not performed |
| pop_refused | output | 1 | Previous cycle's pop was not performed |

## Verification
`ram_addr` and `ram_we` are due in the same cycle as the request. The bench checks them one time unit after it drives the inputs, before the edge that commits them. `full`, `empty`, both refusal flags and the registered read data from the bench's RAM are due one edge later. The bench samples them one time unit after that edge, against an arithmetic model of the pointers and count. A long pseudo-random sweep on an eight-word configuration visits every request combination at every occupancy and wraps the pointers many times, with directed fill, drain, collision and clear sequences before it.

// File: rtl/ramq_pkg.sv
package ramq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } queue_op_t;
endpackage

// File: rtl/ramq_arbiter.sv
module ramq_arbiter
    import ramq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  logic      pop_req,
    input  logic      init_req,
    input  logic      is_full,
    input  logic      is_empty,
    output queue_op_t op,
    output logic      rej_push,
    output logic      rej_pop
);
    // Pop outranks push; clear outranks both.
    always_comb begin
        op = OP_IDLE;
        if (!init_req) begin
            if (pop_req && !is_empty) begin
                op = OP_POP;
            end else if (push_req && !pop_req && !is_full) begin
                op = OP_PUSH;
            end
        end
    end

    always_comb begin
        rej_push = !init_req && push_req && (pop_req || is_full);
        rej_pop  = !init_req && pop_req && is_empty;
    end

    // R5: a write never happens while a pop is requested
    assert_push_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |-> !pop_req);
    // R10: no operation while clearing
    assert_init_blocks_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> (op == OP_IDLE) && !rej_push && !rej_pop);
endmodule

// File: rtl/ramq_ptr.sv
module ramq_ptr #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R2/R3: a stepped pointer moves by exactly one, wrapping
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));
    // R3: an idle pointer holds its value
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(ptr));
endmodule

// File: rtl/ramq_occupancy.sv
module ramq_occupancy
    import ramq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic do_push,
    input  logic do_pop,
    input  logic rej_push,
    input  logic rej_pop,
    output logic is_full,
    output logic is_empty,
    output logic push_refused,
    output logic pop_refused
);
    localparam int CW = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_C  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    occ_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (do_push) begin
            cnt_d = cnt_q + 1'b1;
        end else if (do_pop) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_push) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (do_push && cnt_q == LAST_C) state_d = ST_FULL;
                else if (do_pop && cnt_q == ONE_C) state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (do_pop) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
        if (clr) state_d = ST_EMPTY;
    end

    // State and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_refused <= 1'b0;
            pop_refused  <= 1'b0;
        end else begin
            push_refused <= rej_push && !clr;
            pop_refused  <= rej_pop && !clr;
        end
    end

    always_comb begin
        is_full  = (state_q == ST_FULL);
        is_empty = (state_q == ST_EMPTY);
    end

    // R8: state agrees with the occupancy count
    assert_state_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FULL) == (cnt_q == DEPTH_C)) &&
        ((state_q == ST_EMPTY) == (cnt_q == '0)));
    // R8: count never exceeds the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);
    // R1: clear empties the queue and drops the flags
    assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> is_empty && !is_full && !push_refused && !pop_refused);
    // R6: a push refused while full leaves the count alone
    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && !do_pop && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ramq_ctrl.sv
module ramq_ctrl
    import ramq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              init_req,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              full,
    output logic              empty,
    output logic              push_refused,
    output logic              pop_refused
);
    queue_op_t         op;
    logic              rej_push, rej_pop;
    logic              do_push, do_pop;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;

    ramq_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .init_req (init_req),
        .is_full  (full),
        .is_empty (empty),
        .op       (op),
        .rej_push (rej_push),
        .rej_pop  (rej_pop)
    );

    always_comb begin
        do_push = (op == OP_PUSH);
        do_pop  = (op == OP_POP);
    end

    ramq_ptr #(.ADDR_W(ADDR_W)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_req),
        .step  (do_push),
        .ptr   (wr_ptr)
    );

    ramq_ptr #(.ADDR_W(ADDR_W)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_req),
        .step  (do_pop),
        .ptr   (rd_ptr)
    );

    ramq_occupancy #(.ADDR_W(ADDR_W)) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (init_req),
        .do_push      (do_push),
        .do_pop       (do_pop),
        .rej_push     (rej_push),
        .rej_pop      (rej_pop),
        .is_full      (full),
        .is_empty     (empty),
        .push_refused (push_refused),
        .pop_refused  (pop_refused)
    );

    // Address mux: write pointer only for an accepted push
    always_comb begin
        ram_we   = do_push;
        ram_addr = do_push ? wr_ptr : rd_ptr;
    end

    // R6: no write into a full queue
    assert_we_needs_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !full);
    // R8: full and empty are exclusive
    assert_full_xor_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R5: collision yields a push refusal next cycle
    assert_collision_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !init_req) |=> push_refused);
    // R7: pop from empty yields a pop refusal next cycle
    assert_pop_empty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !init_req) |=> pop_refused);
endmodule

// File: tb/tb_ramq_ctrl.sv
module tb_ramq_ctrl;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_req = 1'b0, pop_req = 1'b0, init_req = 1'b0;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we, full, empty, push_refused, pop_refused;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    int wp = 0, rp = 0, cnt = 0;
    int qval [0:4095];
    int qhead = 0, qtail = 0;
    int next_val = 1;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural RAM
    logic [15:0] mem [DEPTH];
    logic [15:0] wdata = '0, rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= wdata;
        rdata <= mem[ram_addr];
    end

    ramq_ctrl #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .init_req(init_req), .ram_addr(ram_addr), .ram_we(ram_we), .full(full),
        .empty(empty), .push_refused(push_refused), .pop_refused(pop_refused)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at t, check comb outputs at t+1, edge, check registered outputs.
    task automatic cyc(input bit p, input bit q, input bit i);
        bit acc_push, acc_pop, exp_np, exp_nq;
        int exp_addr, exp_data;
        push_req = p; pop_req = q; init_req = i;
        wdata = 16'(next_val);
        acc_push = p && !q && !i && (cnt < DEPTH);
        acc_pop  = q && !i && (cnt > 0);
        exp_addr = acc_push ? wp : rp;
        exp_np = !i && p && (q || cnt == DEPTH);
        exp_nq = !i && q && (cnt == 0);
        exp_data = acc_pop ? qval[qhead] : 0;
        #1;
        check(ram_we == acc_push, "R2/R4/R6/R10 we", int'(ram_we), int'(acc_push));
        check(int'(ram_addr) == exp_addr, "R2/R3/R4 addr", int'(ram_addr), exp_addr);
        @(posedge clk);
        #1;
        if (i) begin
            wp = 0; rp = 0; cnt = 0; qhead = qtail;
        end else if (acc_push) begin
            wp = (wp + 1) % DEPTH; cnt++;
            qval[qtail] = next_val; qtail++; next_val++;
        end else if (acc_pop) begin
            rp = (rp + 1) % DEPTH; cnt--; qhead++;
        end
        if (acc_pop)
            check(int'(rdata) == exp_data, "R9 order", int'(rdata), exp_data);
        check(full == (cnt == DEPTH), "R8 full", int'(full), int'(cnt == DEPTH));
        check(empty == (cnt == 0), "R8/R1 empty", int'(empty), int'(cnt == 0));
        check(push_refused == exp_np, "R5/R6/R11 push_refused", int'(push_refused), int'(exp_np));
        check(pop_refused == exp_nq, "R7/R11 pop_refused", int'(pop_refused), int'(exp_nq));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        // R1: reset state
        check(empty == 1'b1, "R1 reset empty", int'(empty), 1);
        check(full == 1'b0, "R1 reset full", int'(full), 0);
        check(!push_refused && !pop_refused, "R1 reset flags",
              int'({push_refused, pop_refused}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R2/R8: fill to full
        for (int k = 0; k < DEPTH; k++) cyc(1, 0, 0);
        // R6: push while full
        cyc(1, 0, 0); cyc(1, 0, 0);
        // R4: idle
        cyc(0, 0, 0);
        // R5: collision while full performs the pop
        cyc(1, 1, 0);
        // R3/R9: drain
        for (int k = 0; k < DEPTH; k++) cyc(0, 1, 0);
        // R7: pop while empty, then collision while empty
        cyc(0, 1, 0); cyc(1, 1, 0); cyc(0, 0, 0);
        // R10: init with requests, mid-fill
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 1); cyc(1, 0, 1);
        // R1: first push after init goes to word 0
        cyc(1, 0, 0); cyc(0, 1, 0);
        // near-exhaustive sweep, pointers wrap many times
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[1] & lfsr[7], (lfsr[4:0] == 5'd0) && lfsr[9]);
        end
        push_req = 0; pop_req = 0; init_req = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule